// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing controller of a 256-byte serial memory that answers on a two-wire bus made of a clock line (SCL) and an open-drain data line (SDA). Both lines are sampled by a fast system clock through two-flop synchronisers. Their edges are found in the system clock domain, so the system clock must run at least 16 times faster than SCL. The block recognises START and STOP conditions and checks a device-select byte against a type code and three strap inputs. It then either receives a word address and data bytes, or sends data bytes from its storage array. SDA is driven only by pulling it low, through `sdaOe`.

Written bytes first go to a small page buffer. On STOP they are copied into the storage array together, and an internal programming interval starts. During that interval the block refuses to acknowledge its device-select byte. An 8-bit word pointer advances after every byte transferred in either direction and wraps from 255 to 0. A read with no word address starts at this pointer. A random read is a word-address write followed by a repeated START with the read flag set.

Top module: `smem_slave`

## Requirements
- R1: After reset the SDA enable is low (line released), every storage byte reads as 0x00 and the word pointer is 0.
- R2: START (SDA falls while SCL is high) at any point, including inside a byte, returns the engine to receiving a device-select byte. STOP (SDA rises while SCL is high) inside a byte ends the transfer, and the next device-select byte is acknowledged.
- R3: The device-select byte is taken MSB first. Bits 7..4 must equal 1010 when TYPE_SEL is 0, or 0010 when TYPE_SEL is 1. Bits 3..1 must equal strapSel[2:0]. Bit 0 set to 1 selects a read. On a match the slave holds SDA low for the ninth clock; on a mismatch it leaves SDA released.
- R4: In a write, the byte after the device-select byte is the word address. The slave acknowledges it and each following data byte. The data bytes are stored at consecutive addresses when STOP arrives.
- R5: The word pointer advances by one after every data byte read or written, and wraps from 255 to 0.
- R6: A read that is not preceded by a word address returns data starting at the current pointer.
- R7: A word-address write followed by a repeated START with the read flag set returns data starting at that address.
- R8: Bytes are sent MSB first for as long as the master acknowledges. After a master non-acknowledge, the slave leaves SDA released so that the master can send STOP.
- R9: A STOP that ends a write holding at least one data byte starts a programming interval of BUSY_CYCLES clocks. During that interval the device-select byte is not acknowledged; after it, the byte is acknowledged again.
- R10: A data byte beyond PAGE_BYTES in one write is not acknowledged. No byte of that write is stored, and no programming interval starts.
- R11: The SDA enable changes only while the synchronised SCL is low.
- R12: A START that arrives after data bytes but before STOP discards those bytes. They are not stored and no programming interval starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapSel | input | 3 | Device strap inputs, compared with select bits 3..1 |
| sdaOe | output | 1 | When high, the pad pulls SDA low |

## Verification
The bench builds the block with TYPE_SEL set to 0, strapSel tied to 101, PAGE_BYTES at 8 and BUSY_CYCLES cut to 1500. With the short interval, the bench can check the refused device-select byte right after a write and the accepted one soon after. With the page of 8, the ninth-byte refusal can be reached within one transfer. The other type code, 0010, is sent as a device-select byte that must be ignored. Write and read-back addresses are chosen at random and include a run that crosses 255 to 0.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_DEVACK,
    ST_ADDR,
    ST_ADDRACK,
    ST_WRDATA,
    ST_WRACK,
    ST_RDDATA,
    ST_RDACK
  } ctrlState_t;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic sampleBit;  // shift synchronised SDA into the receive byte
    logic setPtr;     // load word pointer and page base from receive byte
    logic clrStage;   // empty the page buffer
    logic stageByte;  // append receive byte to page buffer, advance pointer
    logic markOvf;    // page buffer overrun, drop this write
    logic commit;     // STOP seen: program staged bytes if allowed
    logic loadTx;     // fetch byte at pointer, advance pointer
    logic shiftTx;    // move to next transmit bit
    logic drvAck;     // pull SDA low for the ninth clock
    logic drvTx;      // put current transmit bit on SDA
    logic relSda;     // let SDA float high
  } dpStrobe_t;

endpackage

// File: rtl/smem_dpath.sv
module smem_dpath
  import smem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  dpStrobe_t  stb,
  output logic       sclSync,
  output logic       sdaSync,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic [7:0] rxByte,
  output logic       bufFull,
  output logic       busy,
  output logic       sdaOe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [1:0]  sclSh, sdaSh;
  logic        sclPrev, sdaPrev;

  logic [7:0]  mem [DEPTH];
  logic [7:0]  pageBuf [PAGE_BYTES];
  logic [ADDR_W-1:0] ptr, pageBase;
  logic [CNT_W-1:0]  stageCnt;
  logic        ovf;
  logic [BUSY_W-1:0] busyCnt;
  logic [7:0]  txReg, txNext;
  logic        commitGo;

  // two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= 2'b11;
      sdaSh   <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[0], sclIn};
      sdaSh   <= {sdaSh[0], sdaIn};
      sclPrev <= sclSh[1];
      sdaPrev <= sdaSh[1];
    end
  end

  assign sclSync  = sclSh[1];
  assign sdaSync  = sdaSh[1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxByte <= '0;
    else if (stb.sampleBit) rxByte <= {rxByte[6:0], sdaSync};
  end

  // word pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ptr <= '0;
    else if (stb.setPtr)                ptr <= rxByte[ADDR_W-1:0];
    else if (stb.stageByte | stb.loadTx) ptr <= ptr + ADDR_W'(1);
  end

  // page staging
  assign bufFull  = (stageCnt == CNT_W'(PAGE_BYTES));
  assign commitGo = stb.commit && (stageCnt != '0) && !ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
      ovf      <= 1'b0;
      pageBase <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (stb.clrStage) begin
        stageCnt <= '0;
        ovf      <= 1'b0;
      end else if (commitGo) begin
        stageCnt <= '0;
      end else if (stb.stageByte) begin
        stageCnt <= stageCnt + CNT_W'(1);
      end
      if (stb.markOvf) ovf <= 1'b1;
      if (stb.setPtr)  pageBase <= rxByte[ADDR_W-1:0];
      for (int i = 0; i < PAGE_BYTES; i++)
        if (stb.stageByte && stageCnt == CNT_W'(i)) pageBuf[i] <= rxByte;
    end
  end

  // storage array, programmed from the page buffer in one step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commitGo) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (CNT_W'(i) < stageCnt) mem[pageBase + ADDR_W'(i)] <= pageBuf[i];
    end
  end

  // programming interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busyCnt <= '0;
    else if (commitGo)       busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busyCnt != '0)  busyCnt <= busyCnt - BUSY_W'(1);
  end
  assign busy = (busyCnt != '0);

  // transmit shifter and open-drain enable
  always_comb begin
    if (stb.loadTx)       txNext = mem[ptr];
    else if (stb.shiftTx) txNext = {txReg[6:0], 1'b0};
    else                  txNext = txReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      sdaOe <= 1'b0;
    end else begin
      txReg <= txNext;
      if (stb.drvAck)      sdaOe <= 1'b1;
      else if (stb.drvTx)  sdaOe <= ~txNext[7];
      else if (stb.relSda) sdaOe <= 1'b0;
    end
  end

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter bit TYPE_SEL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  input  logic       bufFull,
  input  logic       busy,
  input  logic [2:0] strapSel,
  output dpStrobe_t  stb,
  output ctrlState_t state
);

  localparam logic [3:0] TYPE_CODE = TYPE_SEL ? 4'b0010 : 4'b1010;

  ctrlState_t stateN;
  logic [3:0] bitCnt, bitCntN;
  logic       mAck, mAckN;
  logic       devMatch;

  assign devMatch = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == strapSel) && !busy;

  always_comb begin
    stb     = '0;
    stateN  = state;
    bitCntN = bitCnt;
    mAckN   = mAck;
    if (startDet) begin
      stateN       = ST_DEVSEL;
      bitCntN      = '0;
      stb.relSda   = 1'b1;
      stb.clrStage = 1'b1;
    end else if (stopDet) begin
      stateN     = ST_IDLE;
      stb.relSda = 1'b1;
      stb.commit = 1'b1;
    end else begin
      case (state)
        ST_DEVSEL, ST_ADDR, ST_WRDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.sampleBit = 1'b1;
            bitCntN       = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = '0;
            if (state == ST_DEVSEL) begin
              if (devMatch) begin
                stb.drvAck = 1'b1;
                stateN     = ST_DEVACK;
              end else begin
                stb.relSda = 1'b1;
                stateN     = ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              stb.setPtr   = 1'b1;
              stb.clrStage = 1'b1;
              stb.drvAck   = 1'b1;
              stateN       = ST_ADDRACK;
            end else if (bufFull) begin
              stb.markOvf = 1'b1;
              stb.relSda  = 1'b1;
              stateN      = ST_IDLE;
            end else begin
              stb.stageByte = 1'b1;
              stb.drvAck    = 1'b1;
              stateN        = ST_WRACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (rxByte[0]) begin
              stb.loadTx = 1'b1;
              stb.drvTx  = 1'b1;
              stateN     = ST_RDDATA;
            end else begin
              stb.relSda = 1'b1;
              stateN     = ST_ADDR;
            end
          end
        end
        ST_ADDRACK, ST_WRACK: begin
          if (sclFall) begin
            stb.relSda = 1'b1;
            stateN     = ST_WRDATA;
          end
        end
        ST_RDDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              bitCntN    = '0;
              stb.relSda = 1'b1;
              stateN     = ST_RDACK;
            end else begin
              bitCntN     = bitCnt + 4'd1;
              stb.shiftTx = 1'b1;
              stb.drvTx   = 1'b1;
            end
          end
        end
        ST_RDACK: begin
          if (sclRise) mAckN = ~sdaSync;
          else if (sclFall) begin
            if (mAck) begin
              stb.loadTx = 1'b1;
              stb.drvTx  = 1'b1;
              stateN     = ST_RDDATA;
            end else begin
              stb.relSda = 1'b1;
              stateN     = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= bitCntN;
      mAck   <= mAckN;
    end
  end

endmodule

// File: rtl/smem_slave.sv
module smem_slave
  import smem_pkg::*;
#(
  parameter bit TYPE_SEL    = 1'b0,
  parameter int ADDR_W      = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int BUSY_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  output logic       sdaOe
);

  dpStrobe_t  stb;
  ctrlState_t state;
  logic       sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic       bufFull, busy;

  smem_dpath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte),
    .bufFull(bufFull), .busy(busy), .sdaOe(sdaOe)
  );

  smem_ctrl #(.TYPE_SEL(TYPE_SEL)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaSync(sdaSync),
    .rxByte(rxByte), .bufFull(bufFull), .busy(busy), .strapSel(strapSel),
    .stb(stb), .state(state)
  );

endmodule

// File: rtl/smem_slave_chk.sv
module smem_slave_chk
  import smem_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclSync,
  input logic       startDet,
  input logic       stopDet,
  input logic       busy,
  input logic       sdaOe,
  input ctrlState_t state
);

  // R11
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !$past(sclSync));

  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> state != ST_DEVACK);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaOe);

  // R3
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> state inside {ST_DEVACK, ST_ADDRACK, ST_WRACK, ST_RDDATA});

  // R2
  start_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> state == ST_DEVSEL);

endmodule

bind smem_slave smem_slave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stopDet(stopDet), .busy(busy), .sdaOe(sdaOe), .state(state)
);

// File: tb/smem_slave_tb_top.sv
module smem_slave_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int Q    = 10;
  localparam int BUSY = 1500;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaOe;
  logic       sdaLine;

  int nChecks = 0;
  int nFail = 0;
  int oeViol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  int mptr = 0;

  assign sdaLine = mSda & ~sdaOe;

  always #2 clk = ~clk;

  smem_slave #(.TYPE_SEL(1'b0), .ADDR_W(8), .PAGE_BYTES(8), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .strapSel(strap), .sdaOe(sdaOe)
  );

  // R11: watch the enable against the bench's own SCL
  logic prevOe = 1'b0;
  always @(posedge clk) begin
    if (rstN && sdaOe !== prevOe && scl) oeViol++;
    prevOe <= sdaOe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic qtr();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    mSda = 1'b1; qtr(); scl = 1'b1; qtr(); mSda = 1'b0; qtr(); scl = 1'b0; qtr();
  endtask

  task automatic busStop();
    mSda = 1'b0; qtr(); scl = 1'b1; qtr(); mSda = 1'b1; qtr(); qtr();
  endtask

  task automatic putBit(input bit b);
    mSda = b; qtr(); scl = 1'b1; qtr(); qtr(); scl = 1'b0; qtr();
  endtask

  task automatic getBit(output bit b);
    mSda = 1'b1; qtr(); scl = 1'b1; qtr(); b = sdaLine; qtr(); scl = 1'b0; qtr();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    putBit(!ack);
  endtask

  function automatic logic [7:0] devByte(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic waitBusy();
    repeat (BUSY + 100) @(posedge clk);
    #1;
  endtask

  task automatic writeBlock(input int addr, input int n);
    bit ak;
    logic [7:0] d;
    busStart();
    sendByte(devByte(1'b0), ak); chk(ak, "R4 select ack", ak, 1);
    sendByte(8'(addr), ak);      chk(ak, "R4 address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, ak);
      chk(ak, "R4 data ack", ak, 1);
      model[(addr + i) & 255] = d;
    end
    busStop();
    mptr = (addr + n) & 255;
  endtask

  task automatic readRandom(input int addr, input int n, input string tag);
    bit ak;
    logic [7:0] d;
    busStart();
    sendByte(devByte(1'b0), ak); chk(ak, "R7 select ack", ak, 1);
    sendByte(8'(addr), ak);      chk(ak, "R7 address ack", ak, 1);
    busStart();
    sendByte(devByte(1'b1), ak); chk(ak, "R7 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(d, i != n - 1);
      chk(d == model[(addr + i) & 255], tag, d, model[(addr + i) & 255]);
    end
    busStop();
    mptr = (addr + n) & 255;
  endtask

  task automatic readCurrent(input int n, input string tag);
    bit ak;
    logic [7:0] d;
    busStart();
    sendByte(devByte(1'b1), ak); chk(ak, "R6 select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(d, i != n - 1);
      chk(d == model[(mptr + i) & 255], tag, d, model[(mptr + i) & 255]);
    end
    busStop();
    mptr = (mptr + n) & 255;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] d;
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (10) @(posedge clk);
    #1 rstN = 1'b1;
    qtr();
    chk(sdaOe == 1'b0, "R1 released after reset", sdaOe, 0);

    // R3: wrong strap, wrong type code
    busStart();
    sendByte({4'b1010, 3'b100, 1'b0}, ak); chk(!ak, "R3 strap mismatch nack", ak, 0);
    busStop();
    busStart();
    sendByte({4'b0010, strap, 1'b0}, ak);  chk(!ak, "R3 type mismatch nack", ak, 0);
    busStop();

    // R1/R6: current read from reset pointer
    readCurrent(2, "R1 R6 reset read");

    // R4 then R9 busy refusal
    writeBlock(8'h10, 4);
    busStart();
    sendByte(devByte(1'b0), ak); chk(!ak, "R9 busy nack", ak, 0);
    busStop();
    waitBusy();
    readRandom(8'h10, 4, "R7 R8 random sequential");
    readCurrent(2, "R6 R5 current after read");

    // R5 wrap
    writeBlock(8'hFE, 3);
    waitBusy();
    readRandom(8'hFF, 2, "R5 wrap read");
    readCurrent(1, "R5 pointer after wrap");

    // R10 overrun
    busStart();
    sendByte(devByte(1'b0), ak); sendByte(8'h40, ak);
    for (int i = 0; i < 8; i++) begin
      sendByte(8'hC0 + 8'(i), ak);
      chk(ak, "R10 page byte ack", ak, 1);
    end
    sendByte(8'hEE, ak); chk(!ak, "R10 ninth byte nack", ak, 0);
    busStop();
    busStart();
    sendByte(devByte(1'b0), ak); chk(ak, "R10 no programming interval", ak, 1);
    busStop();
    readRandom(8'h40, 3, "R10 nothing stored");

    // R2 START inside a byte
    busStart();
    sendByte(devByte(1'b0), ak); sendByte(8'h60, ak);
    for (int i = 0; i < 4; i++) putBit(i[0]);
    busStart();
    sendByte(devByte(1'b1), ak); chk(ak, "R2 select after mid-byte start", ak, 1);
    recvByte(d, 1'b0);
    chk(d == model[8'h60], "R2 data after abort", d, model[8'h60]);
    busStop();
    // R2 STOP inside a byte
    busStart();
    sendByte(devByte(1'b0), ak); sendByte(8'h61, ak);
    for (int i = 0; i < 3; i++) putBit(1'b1);
    busStop();
    busStart();
    sendByte(devByte(1'b0), ak); chk(ak, "R2 select after mid-byte stop", ak, 1);
    busStop();

    // R12 START discards staged bytes
    busStart();
    sendByte(devByte(1'b0), ak); sendByte(8'h70, ak);
    sendByte(8'h5A, ak); chk(ak, "R12 data ack", ak, 1);
    busStart();
    sendByte(devByte(1'b0), ak); chk(ak, "R12 not busy", ak, 1);
    busStop();
    readRandom(8'h70, 1, "R12 nothing stored");

    // constrained random write / read-back
    for (int it = 0; it < 6; it++) begin
      int a, n;
      a = int'($urandom % 256);
      n = 1 + int'($urandom % 8);
      writeBlock(a, n);
      waitBusy();
      readRandom(a, n, "R4 R5 random read-back");
    end
    readCurrent(2, "R6 random current read");

    chk(oeViol == 0, "R11 enable change while SCL high", oeViol, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule